// File: doc/BRIEF.md
# PMIC Command Channel

This block is a memory-mapped command channel placed in front of a serial power-management bus master. Software drives the channel through a small register window. For a write it first loads a data word. It then issues one 32-bit command word that names the command class, the direction, a 4-bit target, a byte count of one to four, and a 16-bit register address. The channel decodes the word into a request and hands it to the bus master over a valid/ready handshake. It then waits for a single-cycle response pulse.

A write finishes as soon as its response arrives, and the channel drops back to idle. A read response is trimmed to the requested byte count and stored in a read-data register. The channel then parks in a wait-for-acknowledge state until software writes 1 to the acknowledge register. Software follows progress by polling a 3-bit state field in the status register. Command words that arrive while the channel is busy are dropped and flagged.

Top module: `pmic_cmd_chan`

## Requirements
- R1: After reset, the status register reads 0, `req_valid` is low, and the read-data and write-data registers read 0.
- R2: An accepted command word is decoded onto the request outputs. The class comes from bits 31:30, the write flag from bit 29, the target from bits 27:24, the byte count minus one from bits 17:16 and the address from bits 15:0. Bits 28, 23:18 are ignored.
- R3: All four class codes pass to `req_class` unchanged: 0 register-zero write, 1 plain register, 2 extended register, 3 extended-long register.
- R4: Status bit 0 is the error flag and bits 3:1 hold the state. The state codes are 0 idle, 1 request pending, 2 awaiting response and 6 awaiting acknowledge. No other code ever appears.
- R5: A command word is accepted only in idle. A command word written in any other state leaves the request unchanged and sets the error flag. The error flag clears when the channel re-enters idle.
- R6: The request carries the write-data register value captured when the command is accepted. Later writes to that register do not alter the in-flight request.
- R7: A read response moves the channel to state 6 and places the data in the read-data register. Writing a value with bit 0 set to the acknowledge register returns the channel to idle. A value with bit 0 clear does nothing.
- R8: A write response returns the channel straight to idle, with no acknowledge needed.
- R9: Read-data bytes above the requested byte count read as zero.
- R10: While `req_valid` is high and `req_ready` is low, the request stays asserted and all of its fields hold.
- R11: The register offsets are 0x00 command, 0x04 write data, 0x14 read data, 0x24 acknowledge and 0x28 status. Register reads return data one cycle after `reg_ren`.
- R12: An acknowledge write outside state 6 has no effect on the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wen | input | 1 | Register write strobe |
| reg_ren | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data |
| req_valid | output | 1 | Request to bus master valid |
| req_ready | input | 1 | Bus master accepts request |
| req_class | output | 2 | Command class |
| req_write | output | 1 | Request is a write |
| req_target | output | 4 | Target ID |
| req_len | output | 2 | Byte count minus one |
| req_addr | output | 16 | Target register address |
| req_wdata | output | DATA_W | Write payload |
| rsp_valid | input | 1 | Response pulse from bus master |
| rsp_rdata | input | DATA_W | Response read data |

## Verification
On every cycle the assertions check four things: the state code is always legal, a request is only raised from idle, the request holds while it is stalled, and the error flag is clear whenever idle is re-entered. They also check that a write never parks in the acknowledge state, and that a one-byte read leaves the upper bytes zero. Field decoding, byte trimming for each count, and the capture of write data at acceptance need concrete command words, so only the bench scenarios can show them. The same holds for rejecting commands while busy, for ignoring early or zero acknowledges, and for the status codes seen in each step.

// File: rtl/pmic_chan_pkg.sv
package pmic_chan_pkg;

  typedef enum logic [2:0] {
    CH_IDLE   = 3'd0,
    CH_ISSUE  = 3'd1,
    CH_WAIT   = 3'd2,
    CH_ACKWT  = 3'd6
  } chan_state_e;

  typedef struct packed {
    logic [1:0]  cls;
    logic        wr;
    logic [3:0]  tgt;
    logic [1:0]  len;
    logic [15:0] addr;
  } cmd_fields_t;

  localparam int OFF_CMD   = 'h00;
  localparam int OFF_WDATA = 'h04;
  localparam int OFF_RDATA = 'h14;
  localparam int OFF_ACK   = 'h24;
  localparam int OFF_STAT  = 'h28;

endpackage

// File: rtl/pmic_cmd_decode.sv
module pmic_cmd_decode
  import pmic_chan_pkg::*;
(
  input  logic [31:0]  word,
  output cmd_fields_t  fields
);
  logic unused_rsvd;
  assign unused_rsvd = ^{word[28], word[23:18]};

  always_comb begin
    fields.cls  = word[31:30];
    fields.wr   = word[29];
    fields.tgt  = word[27:24];
    fields.len  = word[17:16];
    fields.addr = word[15:0];
  end
endmodule

// File: rtl/pmic_byte_keep.sv
module pmic_byte_keep #(
  parameter int DATA_W = 32,
  localparam int NBYTES = DATA_W / 8,
  localparam int LEN_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic [DATA_W-1:0] din,
  input  logic [LEN_W-1:0]  len,
  output logic [DATA_W-1:0] dout
);
  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    assign dout[8*i +: 8] = (LEN_W'(i) <= len) ? din[8*i +: 8] : 8'h00;
  end
endmodule

// File: rtl/pmic_chan_fsm.sv
module pmic_chan_fsm
  import pmic_chan_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        cmd_wr,
  input  logic        ack_wr,
  input  logic        is_write,
  input  logic        req_ready,
  input  logic        rsp_valid,
  output chan_state_e state,
  output logic        accept,
  output logic        err
);
  chan_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      CH_IDLE:  if (cmd_wr)    nxt = CH_ISSUE;
      CH_ISSUE: if (req_ready) nxt = CH_WAIT;
      CH_WAIT:  if (rsp_valid) nxt = is_write ? CH_IDLE : CH_ACKWT;
      CH_ACKWT: if (ack_wr)    nxt = CH_IDLE;
      default:                 nxt = CH_IDLE;
    endcase
  end

  assign accept = (state == CH_IDLE) && cmd_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= CH_IDLE;
      err   <= 1'b0;
    end else begin
      state <= nxt;
      if (nxt == CH_IDLE && state != CH_IDLE)
        err <= 1'b0;
      else if (cmd_wr && state != CH_IDLE)
        err <= 1'b1;
    end
  end

  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    state inside {CH_IDLE, CH_ISSUE, CH_WAIT, CH_ACKWT}); // R4
  AST_ISSUE_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
    (state == CH_ISSUE && $past(state) != CH_ISSUE) |-> $past(state) == CH_IDLE); // R5
  AST_ERR_CLEAR_IDLE: assert property (@(posedge clk) disable iff (rst)
    (state == CH_IDLE && $past(state) != CH_IDLE) |-> !err); // R5
  AST_ACK_PARK: assert property (@(posedge clk) disable iff (rst)
    (state == CH_ACKWT && !ack_wr) |=> state == CH_ACKWT); // R7
endmodule

// File: rtl/pmic_cmd_chan.sv
module pmic_cmd_chan
  import pmic_chan_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  localparam int NBYTES = DATA_W / 8,
  localparam int LEN_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wen,
  input  logic              reg_ren,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [1:0]        req_class,
  output logic              req_write,
  output logic [3:0]        req_target,
  output logic [1:0]        req_len,
  output logic [15:0]       req_addr,
  output logic [DATA_W-1:0] req_wdata,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_rdata
);
  localparam logic [ADDR_W-1:0] A_CMD   = ADDR_W'(OFF_CMD);
  localparam logic [ADDR_W-1:0] A_WDATA = ADDR_W'(OFF_WDATA);
  localparam logic [ADDR_W-1:0] A_RDATA = ADDR_W'(OFF_RDATA);
  localparam logic [ADDR_W-1:0] A_ACK   = ADDR_W'(OFF_ACK);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFF_STAT);

  logic              cmd_wr, ack_wr, accept, err;
  chan_state_e       state;
  cmd_fields_t       dec, fld_q;
  logic [DATA_W-1:0] wdata_q, req_wdata_q, rdata_q, kept;
  logic [31:0]       cmd_word;

  assign cmd_wr   = reg_wen && (reg_addr == A_CMD);
  assign ack_wr   = reg_wen && (reg_addr == A_ACK) && reg_wdata[0];
  assign cmd_word = 32'(reg_wdata);

  pmic_cmd_decode u_dec (
    .word   (cmd_word),
    .fields (dec)
  );

  pmic_chan_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .cmd_wr    (cmd_wr),
    .ack_wr    (ack_wr),
    .is_write  (fld_q.wr),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .state     (state),
    .accept    (accept),
    .err       (err)
  );

  pmic_byte_keep #(.DATA_W(DATA_W)) u_keep (
    .din  (rsp_rdata),
    .len  (LEN_W'(fld_q.len)),
    .dout (kept)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wdata_q     <= '0;
      req_wdata_q <= '0;
      fld_q       <= '0;
      rdata_q     <= '0;
      reg_rdata   <= '0;
    end else begin
      if (reg_wen && reg_addr == A_WDATA)
        wdata_q <= reg_wdata;
      if (accept) begin
        fld_q       <= dec;
        req_wdata_q <= wdata_q;
      end
      if (state == CH_WAIT && rsp_valid && !fld_q.wr)
        rdata_q <= kept;
      if (reg_ren) begin
        unique case (reg_addr)
          A_WDATA: reg_rdata <= wdata_q;
          A_RDATA: reg_rdata <= rdata_q;
          A_STAT:  reg_rdata <= {{(DATA_W-4){1'b0}}, state, err};
          default: reg_rdata <= '0;
        endcase
      end
    end
  end

  assign req_valid  = (state == CH_ISSUE);
  assign req_class  = fld_q.cls;
  assign req_write  = fld_q.wr;
  assign req_target = fld_q.tgt;
  assign req_len    = fld_q.len;
  assign req_addr   = fld_q.addr;
  assign req_wdata  = req_wdata_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> (req_valid && $stable(fld_q) && $stable(req_wdata))); // R10
  AST_WRITE_NO_PARK: assert property (@(posedge clk) disable iff (rst)
    (state == CH_ACKWT) |-> !req_write); // R8
  AST_ONE_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (state == CH_ACKWT && req_len == 2'd0) |-> (rdata_q[DATA_W-1:8] == '0)); // R9
  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    (state == CH_IDLE) |-> !req_valid); // R5
endmodule

// File: tb/pmic_cmd_chan_tb.sv
module pmic_cmd_chan_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // {command word, write data, response data, expected read data}
  localparam logic [127:0] VEC [NVEC] = '{
    {32'h4500_1234, 32'h0000_0000, 32'hAABB_CCDD, 32'h0000_00DD},
    {32'hDF03_BEEF, 32'h0000_0000, 32'h1122_3344, 32'h1122_3344},
    {32'h2201_0042, 32'hCAFE_F00D, 32'h0000_0000, 32'h0000_0000},
    {32'hA902_FFFF, 32'h0102_0304, 32'h0000_0000, 32'h0000_0000},
    {32'h8002_0000, 32'h0000_0000, 32'h9988_7766, 32'h0088_7766},
    {32'hC701_5A5A, 32'h0000_0000, 32'hDEAD_BEEF, 32'h0000_BEEF}
  };

  logic clk = 0, rst = 1;
  logic reg_wen = 0, reg_ren = 0;
  logic [5:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic req_valid, req_ready = 0, req_write;
  logic [1:0] req_class, req_len;
  logic [3:0] req_target;
  logic [15:0] req_addr;
  logic [31:0] req_wdata;
  logic rsp_valid = 0;
  logic [31:0] rsp_rdata = '0;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pmic_cmd_chan u_dut (
    .clk(clk), .rst(rst), .reg_wen(reg_wen), .reg_ren(reg_ren),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_class(req_class),
    .req_write(req_write), .req_target(req_target), .req_len(req_len),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); reg_wen = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wen = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); reg_ren = 1; reg_addr = a;
    @(negedge clk); reg_ren = 0; d = reg_rdata;
  endtask

  task automatic handshake();
    @(negedge clk); req_ready = 1;
    @(negedge clk); req_ready = 0;
  endtask

  task automatic respond(input logic [31:0] d);
    @(negedge clk); rsp_valid = 1; rsp_rdata = d;
    @(negedge clk); rsp_valid = 0; rsp_rdata = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 req_valid", 32'(req_valid), 0);
    rd(6'h28, d); chk("R1 status", d, 0);
    rd(6'h14, d); chk("R1 rdata", d, 0);
    rd(6'h04, d); chk("R1 wdata", d, 0);
    rd(6'h00, d); chk("R11 cmd offset reads zero", d, 0);

    for (int i = 0; i < NVEC; i++) begin
      logic [31:0] cw, wd, rp, ex;
      {cw, wd, rp, ex} = VEC[i];
      wr(6'h04, wd);
      rd(6'h04, d); chk("R11 wdata readback", d, wd);
      wr(6'h00, cw);
      chk("R2 valid", 32'(req_valid), 1);
      chk("R3 class", 32'(req_class), 32'(cw[31:30]));
      chk("R2 write", 32'(req_write), 32'(cw[29]));
      chk("R2 target", 32'(req_target), 32'(cw[27:24]));
      chk("R2 len", 32'(req_len), 32'(cw[17:16]));
      chk("R2 addr", 32'(req_addr), 32'(cw[15:0]));
      if (cw[29]) begin
        wr(6'h04, ~wd);
        chk("R6 wdata captured", req_wdata, wd);
      end
      rd(6'h28, d); chk("R4 status pending", d, 32'h2);
      chk("R10 held", {req_valid, req_target, req_addr}, {1'b1, cw[27:24], cw[15:0]});
      handshake();
      chk("R10 dropped after ready", 32'(req_valid), 0);
      rd(6'h28, d); chk("R4 status wait", d, 32'h4);
      respond(rp);
      rd(6'h28, d);
      if (cw[29]) begin
        chk("R8 write back to idle", d, 0);
      end else begin
        chk("R7 parked", d, 32'hC);
        rd(6'h14, d); chk("R9 rdata trimmed", d, ex);
        wr(6'h24, 32'h0);
        rd(6'h28, d); chk("R7 ack zero ignored", d, 32'hC);
        wr(6'h24, 32'h1);
        rd(6'h28, d); chk("R7 ack to idle", d, 0);
      end
    end

    // R5, R12: busy rejection and early acknowledge
    wr(6'h00, 32'h4500_1234);
    wr(6'h00, 32'h3F0F_0000);
    rd(6'h28, d); chk("R5 error set", d, 32'h3);
    chk("R5 target kept", 32'(req_target), 32'h5);
    chk("R5 addr kept", 32'(req_addr), 32'h1234);
    handshake();
    wr(6'h24, 32'h1);
    rd(6'h28, d); chk("R12 early ack ignored", d, 32'h5);
    respond(32'h0102_0304);
    rd(6'h28, d); chk("R5 error sticky", d, 32'hD);
    rd(6'h14, d); chk("R9 one byte", d, 32'h04);
    wr(6'h24, 32'h1);
    rd(6'h28, d); chk("R5 error cleared", d, 0);
    wr(6'h24, 32'h1);
    rd(6'h28, d); chk("R12 idle ack ignored", d, 0);
    rsp_valid = 1; @(negedge clk); rsp_valid = 0;
    rd(6'h14, d); chk("R7 stray response ignored", d, 32'h04);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule